// File: doc/BRIEF.md
# Mode-switchable operand data cache

This block sits between a processor's load/store port and a plain external memory port. It keeps recently used 32-byte lines on chip and moves whole lines to and from memory as eight sequential 32-bit beats. Three control bits are held in a small configuration register that is loaded through the `cfg_*` pins. The first bit selects the organisation: a direct-mapped cache that uses one way of the storage, or a 2-way set-associative cache with one LRU bit per set. The second bit gives the second way of storage to software as directly addressed on-chip RAM. The third bit selects copy-back or write-through stores.

The processor side uses a valid/ready handshake on 32-bit words. A hit, or any access to the on-chip RAM window, completes in the cycle it is presented. A miss holds ready low while the block writes back a dirty victim, when there is one, and then refills the line. After the refill the access completes as a hit. A change of organisation or of RAM mode invalidates every line. Software is expected to clean the cache first, because dirty data is dropped at that point.

Top module: `dc_opcache`

## Requirements
- R1: After reset the configuration bits are all 0, which selects the direct-mapped organisation, copy-back stores and no RAM window. Every line is invalid, and with `cpu_valid` low neither `cpu_ready` nor `mem_req` is asserted.
- R2: A read that misses a clean victim issues exactly eight memory read beats. The beats run at ascending word addresses from the line base. The access then returns the stored word, completing 10 cycles after it is presented when memory acknowledges every beat at once.
- R3: With `cfg_ext`=0 the cache is direct-mapped. A word address splits into the word in line [4:2], the set index [4+IDX_W:5] and the tag (the bits above). Two lines with equal index and different tags evict each other.
- R4: With `cfg_ext`=1 and `cfg_ram`=0 each set holds two lines. Every hit and every refill points the set's LRU bit at the other way, and a miss replaces the way that bit names.
- R5: In copy-back mode a write hit completes in 1 cycle with no memory traffic and marks the line dirty. A write miss allocates the line (10 cycles). A dirty victim is written back as eight beats before the refill begins (18 cycles in total), and memory then holds the written data.
- R6: In write-through mode every write completes when memory accepts a single beat for that word, 2 cycles after it is presented. A write hit also updates the cached copy. A write miss allocates nothing, so a later read of that address misses.
- R7: With `cfg_ram`=1, addresses whose tag equals `RAM_TAG` read and write the second storage way as RAM, in 1 cycle and with no memory traffic. In that mode the cache is direct-mapped whatever `cfg_ext` holds.
- R8: A configuration load that changes `cfg_ext` or `cfg_ram` invalidates every line without writing anything back. A load that leaves both bits unchanged keeps the contents.
- R9: A read hit asserts `cpu_ready` in the cycle `cpu_valid` is presented and returns the latest data written to that address.
- R10: `cpu_ready` is never high while `cpu_valid` is low. During a miss it stays low until the refill has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the three configuration bits |
| cfg_ext | input | 1 | 1 = 2-way LRU organisation, 0 = direct-mapped |
| cfg_ram | input | 1 | 1 = second way used as on-chip RAM |
| cfg_wt | input | 1 | 1 = write-through, 0 = copy-back |
| cpu_valid | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | 32 | Read beat data |

## Verification
With memory acknowledging every beat at once, each access has a fixed number of cycles from presentation to completion. A hit or RAM access takes 1 cycle. A write-through store takes 2. A clean miss takes 10, and a miss with a dirty victim takes 18. The bench drives each request just after a falling edge and samples `cpu_ready` a moment later. It counts rising edges up to the one at which the handshake completes and compares that count to the figure for the expected case. Memory beat counters and the memory contents are read after the access has completed, so write-backs are checked once all eight beats are done.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
   localparam int WORD_W = 32;
   localparam int BEAT_W = 3;
   localparam int OFF_W  = 5;
   typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL, ST_WTHRU} dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 21
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  fill_we,
   input  logic                  fill_way,
   input  logic [TAG_W-1:0]      fill_tag,
   input  logic                  dirty_we,
   input  logic                  dirty_way,
   output logic [1:0][TAG_W-1:0] tag_q,
   output logic [1:0]            vld_q,
   output logic [1:0]            dty_q
);
   localparam int SETS = 2 ** IDX_W;

   if (IDX_W < 1) begin : g_bad_idx
      $error("dc_tag_store: IDX_W must be at least 1");
   end

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vbits;
      logic [SETS-1:0]  dbits;

      always_ff @(posedge clk) begin
         if (fill_we && fill_way == 1'(w)) tags[idx] <= fill_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vbits <= '0;
            dbits <= '0;
         end else if (flush) begin
            vbits <= '0;
            dbits <= '0;
         end else begin
            if (fill_we && fill_way == 1'(w)) begin
               vbits[idx] <= 1'b1;
               dbits[idx] <= 1'b0;
            end
            if (dirty_we && dirty_way == 1'(w)) dbits[idx] <= 1'b1;
         end
      end

      assign tag_q[w] = tags[idx];
      assign vld_q[w] = vbits[idx];
      assign dty_q[w] = dbits[idx];
   end
endmodule

// File: rtl/dc_data_store.sv
`timescale 1ns/1ps
module dc_data_store import dc_pkg::*; #(
   parameter int IDX_W = 6
) (
   input  logic              clk,
   input  logic              rd_way,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BEAT_W-1:0] rd_word,
   output logic [WORD_W-1:0] rdata,
   input  logic              we,
   input  logic              wr_way,
   input  logic [BEAT_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wdata
);
   localparam int AW = 1 + IDX_W + BEAT_W;

   logic [WORD_W-1:0] words [2**AW];

   always_ff @(posedge clk) begin
      if (we) words[{wr_way, idx, wr_word}] <= wdata;
   end

   assign rdata = words[{rd_way, idx, rd_word}];
endmodule

// File: rtl/dc_lru.sv
`timescale 1ns/1ps
module dc_lru #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             upd_en,
   input  logic             used_way,
   output logic             lru_q
);
   logic [2**IDX_W-1:0] bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits <= '0;
      else if (upd_en) bits[idx] <= ~used_way;
   end

   assign lru_q = bits[idx];
endmodule

// File: rtl/dc_opcache.sv
`timescale 1ns/1ps
module dc_opcache import dc_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter logic [ADDR_W-OFF_W-IDX_W-1:0] RAM_TAG = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_ext,
   input  logic              cfg_ram,
   input  logic              cfg_wt,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   if (TAG_W < 1) begin : g_bad_addr
      $error("dc_opcache: ADDR_W leaves no tag bits");
   end

   dc_state_e st, st_nx;
   logic [BEAT_W-1:0] beat, beat_nx;
   logic ext_q, ram_q, wt_q, vic_q;

   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [BEAT_W-1:0] a_word;
   assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx  = cpu_addr[OFF_W +: IDX_W];
   assign a_word = cpu_addr[2 +: BEAT_W];

   logic [1:0][TAG_W-1:0] tag_q;
   logic [1:0] vld_q, dty_q;
   logic lru_q;
   logic [WORD_W-1:0] drd;

   logic two_way, ram_hit, hit0, hit1, hit, hit_way, vic_sel, flush;
   logic xfer, fill_done, dwe, dway, lru_upd;
   assign two_way = ext_q && !ram_q;
   assign ram_hit = ram_q && (a_tag == RAM_TAG);
   assign hit0    = vld_q[0] && (tag_q[0] == a_tag);
   assign hit1    = two_way && vld_q[1] && (tag_q[1] == a_tag);
   assign hit     = !ram_hit && (hit0 || hit1);
   assign hit_way = hit1;
   assign vic_sel = two_way ? lru_q : 1'b0;
   assign flush   = cfg_wr && ((cfg_ext != ext_q) || (cfg_ram != ram_q));
   assign xfer      = cpu_valid && cpu_ready;
   assign fill_done = (st == ST_FILL) && mem_ack && (beat == 3'd7);
   assign dwe  = ((st == ST_FILL) && mem_ack) || (xfer && cpu_we && (hit || ram_hit));
   assign dway = (st == ST_FILL) ? vic_q : (ram_hit ? 1'b1 : hit_way);
   assign lru_upd = (xfer && hit) || fill_done;

   dc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .flush(flush), .idx(a_idx),
      .fill_we(fill_done), .fill_way(vic_q), .fill_tag(a_tag),
      .dirty_we(xfer && cpu_we && hit && !wt_q), .dirty_way(hit_way),
      .tag_q(tag_q), .vld_q(vld_q), .dty_q(dty_q));

   dc_data_store #(.IDX_W(IDX_W)) u_data (
      .clk(clk),
      .rd_way((st == ST_WBACK) ? vic_q : (ram_hit ? 1'b1 : hit_way)),
      .idx(a_idx),
      .rd_word((st == ST_WBACK) ? beat : a_word),
      .rdata(drd), .we(dwe), .wr_way(dway),
      .wr_word((st == ST_FILL) ? beat : a_word),
      .wdata((st == ST_FILL) ? mem_rdata : cpu_wdata));

   dc_lru #(.IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .idx(a_idx), .upd_en(lru_upd),
      .used_way(fill_done ? vic_q : hit_way), .lru_q(lru_q));

   always_comb begin
      st_nx     = st;
      beat_nx   = beat;
      cpu_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = drd;
      case (st)
         ST_IDLE: if (cpu_valid) begin
            if (ram_hit)                cpu_ready = 1'b1;
            else if (cpu_we && wt_q)    st_nx = ST_WTHRU;
            else if (hit)               cpu_ready = 1'b1;
            else begin
               beat_nx = '0;
               st_nx   = (vld_q[vic_sel] && dty_q[vic_sel]) ? ST_WBACK : ST_FILL;
            end
         end
         ST_WTHRU: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            if (mem_ack) begin
               cpu_ready = 1'b1;
               st_nx     = ST_IDLE;
            end
         end
         ST_WBACK: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = {tag_q[vic_q], a_idx, beat, 2'b00};
            if (mem_ack) begin
               beat_nx = beat + 3'd1;
               if (beat == 3'd7) st_nx = ST_FILL;
            end
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {a_tag, a_idx, beat, 2'b00};
            if (mem_ack) begin
               beat_nx = beat + 3'd1;
               if (beat == 3'd7) st_nx = ST_IDLE;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   assign cpu_rdata = drd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         beat  <= '0;
         vic_q <= 1'b0;
         ext_q <= 1'b0;
         ram_q <= 1'b0;
         wt_q  <= 1'b0;
      end else begin
         st   <= st_nx;
         beat <= beat_nx;
         if (st == ST_IDLE) vic_q <= vic_sel;
         if (cfg_wr) begin
            ext_q <= cfg_ext;
            ram_q <= cfg_ram;
            wt_q  <= cfg_wt;
         end
      end
   end

   // R2
   fill_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && mem_ack && beat != 3'd7) |=> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

   // R5
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WBACK && mem_ack && beat == 3'd7) |=> (st == ST_FILL && !mem_we));

   // R7
   ram_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cpu_valid && ram_hit) |=> (st == ST_IDLE));

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);

   // R10
   ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_valid);
endmodule

// File: tb/dc_opcache_test.sv
`timescale 1ns/1ps
module dc_opcache_test;
   localparam int AW = 12;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_ext = 1'b0, cfg_ram = 1'b0, cfg_wt = 1'b0;
   logic cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic cpu_ready;
   logic [31:0] cpu_rdata;
   logic mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;

   always #4 clk = ~clk;

   dc_opcache #(.ADDR_W(AW), .IDX_W(IW), .RAM_TAG(5'h1F)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext(cfg_ext),
      .cfg_ram(cfg_ram), .cfg_wt(cfg_wt), .cpu_valid(cpu_valid),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   function automatic logic [31:0] initv(int i);
      return 32'hA500_0000 ^ (32'(i) * 32'h0001_0103);
   endfunction

   function automatic logic [AW-1:0] mk(int t, int s, int w);
      return {t[4:0], s[1:0], w[2:0], 2'b00};
   endfunction

   logic [31:0] model  [1024];
   logic [31:0] golden [1024];
   int rd_beats = 0, wr_beats = 0;
   int n_chk = 0, n_fail = 0;

   assign mem_ack   = mem_req;
   assign mem_rdata = model[mem_addr[11:2]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) model[i] <= initv(i);
      end else if (mem_req && mem_ack) begin
         if (mem_we) begin
            model[mem_addr[11:2]] <= mem_wdata;
            wr_beats <= wr_beats + 1;
         end else begin
            rd_beats <= rd_beats + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc);
      bit got;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      cyc = 0;
      while (1) begin
         #1;
         got = cpu_ready;
         rd  = cpu_rdata;
         @(posedge clk);
         cyc++;
         if (got) break;
         @(negedge clk);
      end
      #1 cpu_valid = 1'b0; cpu_we = 1'b0;
      if (we) golden[a[11:2]] = wd;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input int exp_cyc, input string req);
      logic [31:0] d;
      int c;
      access(1'b0, a, 32'h0, d, c);
      chk(d == golden[a[11:2]], req, d, golden[a[11:2]]);
      chk(c == exp_cyc, req, 32'(c), 32'(exp_cyc));
   endtask

   task automatic wr_chk(input logic [AW-1:0] a, input logic [31:0] v, input int exp_cyc, input string req);
      logic [31:0] d;
      int c;
      access(1'b1, a, v, d, c);
      chk(c == exp_cyc, req, 32'(c), 32'(exp_cyc));
   endtask

   task automatic set_cfg(input logic e, input logic r, input logic w);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_ext = e; cfg_ram = r; cfg_wt = w;
      @(posedge clk);
      #1 cfg_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int b0, w0;
      for (int i = 0; i < 1024; i++) golden[i] = initv(i);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 / R10: idle after reset, no request and no ready
      chk(mem_req == 1'b0, "R1", 32'(mem_req), 0);
      chk(cpu_ready == 1'b0, "R10", 32'(cpu_ready), 0);

      // R2: clean read misses in the reset (direct-mapped) organisation
      for (int s = 0; s < 4; s++) begin
         b0 = rd_beats;
         rd_chk(mk(1, s, s), 10, "R2");
         chk(rd_beats - b0 == 8, "R2", 32'(rd_beats - b0), 8);
      end
      // R9: every word of every filled line hits in one cycle
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 8; w++) rd_chk(mk(1, s, w), 1, "R9");

      // R3 / R1: reset organisation is direct-mapped, same index conflicts
      rd_chk(mk(2, 0, 0), 10, "R3");
      rd_chk(mk(1, 0, 0), 10, "R3");

      // R5: copy-back write hit, dirty eviction, write-allocate
      w0 = wr_beats;
      wr_chk(mk(1, 0, 3), 32'hDEAD_0001, 1, "R5");
      chk(wr_beats == w0, "R5", 32'(wr_beats), 32'(w0));
      rd_chk(mk(1, 0, 3), 1, "R5");
      chk(model[mk(1, 0, 3) >> 2] != 32'hDEAD_0001, "R5", model[mk(1, 0, 3) >> 2], initv(mk(1, 0, 3) >> 2));
      w0 = wr_beats;
      rd_chk(mk(3, 0, 0), 18, "R5");
      chk(wr_beats - w0 == 8, "R5", 32'(wr_beats - w0), 8);
      chk(model[mk(1, 0, 3) >> 2] == 32'hDEAD_0001, "R5", model[mk(1, 0, 3) >> 2], 32'hDEAD_0001);
      chk(model[mk(1, 0, 7) >> 2] == golden[mk(1, 0, 7) >> 2], "R5", model[mk(1, 0, 7) >> 2], golden[mk(1, 0, 7) >> 2]);
      w0 = wr_beats;
      wr_chk(mk(2, 1, 5), 32'hBEEF_0002, 10, "R5");
      chk(wr_beats == w0, "R5", 32'(wr_beats), 32'(w0));
      rd_chk(mk(2, 1, 5), 1, "R5");
      rd_chk(mk(0, 1, 0), 18, "R5");
      chk(model[mk(2, 1, 5) >> 2] == 32'hBEEF_0002, "R5", model[mk(2, 1, 5) >> 2], 32'hBEEF_0002);

      // R8: organisation change invalidates, unchanged load keeps lines
      rd_chk(mk(1, 2, 4), 1, "R8");
      w0 = wr_beats;
      set_cfg(1'b1, 1'b0, 1'b0);
      chk(wr_beats == w0, "R8", 32'(wr_beats), 32'(w0));
      rd_chk(mk(1, 2, 4), 10, "R8");
      set_cfg(1'b1, 1'b0, 1'b0);
      rd_chk(mk(1, 2, 4), 1, "R8");

      // R4: two ways with LRU replacement on set 3
      rd_chk(mk(4, 3, 0), 10, "R4");
      rd_chk(mk(5, 3, 1), 10, "R4");
      rd_chk(mk(4, 3, 0), 1, "R4");
      rd_chk(mk(5, 3, 1), 1, "R4");
      rd_chk(mk(6, 3, 2), 10, "R4");
      rd_chk(mk(5, 3, 1), 1, "R4");
      rd_chk(mk(4, 3, 0), 10, "R4");
      rd_chk(mk(5, 3, 1), 1, "R4");
      rd_chk(mk(6, 3, 2), 10, "R4");
      rd_chk(mk(5, 3, 1), 1, "R4");

      // R6: write-through (ext unchanged, so no invalidation)
      set_cfg(1'b1, 1'b0, 1'b1);
      w0 = wr_beats;
      wr_chk(mk(5, 3, 1), 32'hC0FF_EE03, 2, "R6");
      chk(wr_beats - w0 == 1, "R6", 32'(wr_beats - w0), 1);
      chk(model[mk(5, 3, 1) >> 2] == 32'hC0FF_EE03, "R6", model[mk(5, 3, 1) >> 2], 32'hC0FF_EE03);
      rd_chk(mk(5, 3, 1), 1, "R6");
      wr_chk(mk(7, 0, 1), 32'h0BAD_0004, 2, "R6");
      chk(model[mk(7, 0, 1) >> 2] == 32'h0BAD_0004, "R6", model[mk(7, 0, 1) >> 2], 32'h0BAD_0004);
      rd_chk(mk(7, 0, 1), 10, "R6");

      // R7: RAM window on the second way, single cycle, no memory traffic
      set_cfg(1'b1, 1'b1, 1'b0);
      b0 = rd_beats;
      w0 = wr_beats;
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 8; w++) wr_chk(mk(31, s, w), 32'h7000_0000 + 32'(s * 8 + w), 1, "R7");
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 8; w++) rd_chk(mk(31, s, w), 1, "R7");
      chk(rd_beats == b0 && wr_beats == w0, "R7", 32'(rd_beats + wr_beats), 32'(b0 + w0));
      chk(model[mk(31, 2, 5) >> 2] == initv(mk(31, 2, 5) >> 2), "R7", model[mk(31, 2, 5) >> 2], initv(mk(31, 2, 5) >> 2));
      // R7: cache is direct-mapped while the RAM window is on
      rd_chk(mk(1, 2, 0), 10, "R7");
      rd_chk(mk(2, 2, 0), 10, "R7");
      rd_chk(mk(1, 2, 0), 10, "R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule